// File: doc/BRIEF.md
# Segmented Address Generation Unit

This block turns a segment value and an offset into a linear address. When the protected-mode control bit is clear it works in the legacy real mode: the 16-bit segment value is multiplied by sixteen and the low 16 bits of the offset are added, giving a result that may carry past 1 MB. When the control bit is set, the segment register holds a selector and the block uses a hidden copy of the descriptor that was loaded into that register. The descriptor gives the base, the limit, the granularity, whether the segment is present, whether it is code, and whether it may be written (for data) or read (for code). The block adds the offset to the base. It checks the access kind against the rights and checks the last byte touched against the limit.

The descriptor-load port writes one hidden entry per segment register. Fetching descriptors from the tables in memory is done elsewhere. A load whose descriptor is marked not present is refused and flagged. An active-low mask input forces linear address bit 20 to zero in both modes. Every request produces a registered response one cycle later. The response carries the address, or a fault code with the address held at zero.

Top module: `seg_agu`

## Requirements
- R1: With `ctl_pe`=0 the address is `req_seg_val`*16 + `req_offset[15:0]`. Offset bits 31:16 are ignored and no fault is ever reported.
- R2: With `a20_mask_n`=0 the response address bit 20 is 0 in both modes. With `a20_mask_n`=1, segment FFFFh with offset FFFFh gives 10FFEFh.
- R3: Each cycle with `req_valid`=1 gives `rsp_valid`=1 in the next cycle. A cycle without a request gives `rsp_valid`=0 in the next cycle.
- R4: A load with `ld_present`=1 replaces the hidden entry `ld_seg_idx` at the clock edge, and the next cycle's requests use it.
   - The protected-mode address is base + offset, modulo 2^32.
   - `rsp_ti` is selector bit 2, `rsp_rpl` is selector bits 1:0, and `rsp_index` is selector bits 15:3. All three are 0 in real mode.
- R5: A load with `ld_present`=0 sets `ld_fault`=1 in the next cycle and leaves the old hidden entry in use. A present load gives `ld_fault`=0.
- R6: With granularity 0 the limit counts bytes. An access whose last byte, offset + `req_size`, exceeds the limit gets fault code 1 (limit). `req_size` is the byte count minus one, 0 to 3.
- R7: With granularity 1 the effective limit is {limit, FFFh}, and the same last-byte comparison is made against it. An access whose end passes 2^32 also faults with code 1.
- R8: Access kinds are 0=read, 1=write, 2=execute. Each of the following gets fault code 2 (rights):
   - a write to a code segment;
   - a write to a data segment that is not writable;
   - an execute from a data segment;
   - a read from a code segment that is not readable.
   A rights fault takes priority over a limit fault.
- R9: In protected mode, a request to an entry that has held no present descriptor since reset gets fault code 3 (not present).
- R10: Whenever the fault code is not 0, the response address is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_pe | input | 1 | 1 = protected mode, 0 = real mode |
| a20_mask_n | input | 1 | Active-low force of address bit 20 to zero |
| ld_valid | input | 1 | Descriptor load strobe |
| ld_seg_idx | input | IDX_W | Segment register written by the load |
| ld_selector | input | 16 | Selector loaded with the descriptor |
| ld_base | input | ADDR_W | Descriptor base |
| ld_limit | input | LIM_W | Descriptor limit |
| ld_gran | input | 1 | Granularity, 1 = 4 KB units |
| ld_present | input | 1 | Descriptor present bit |
| ld_code | input | 1 | 1 = code segment |
| ld_rw | input | 1 | Writable (data) or readable (code) |
| req_valid | input | 1 | Translation request |
| req_seg_idx | input | IDX_W | Segment register used in protected mode |
| req_seg_val | input | 16 | Segment value used in real mode |
| req_offset | input | ADDR_W | Offset |
| req_kind | input | 2 | 0 read, 1 write, 2 execute |
| req_size | input | 2 | Access bytes minus one |
| ld_fault | output | 1 | Refused load, one cycle after it |
| rsp_valid | output | 1 | Response valid |
| rsp_addr | output | ADDR_W | Linear address, 0 on fault |
| rsp_fault | output | 2 | 0 none, 1 limit, 2 rights, 3 not present |
| rsp_ti | output | 1 | Table indicator of the cached selector |
| rsp_rpl | output | 2 | Requested privilege of the cached selector |
| rsp_index | output | 13 | Descriptor index of the cached selector |

## Verification
The bench builds the unit with six segment registers. Six is not a power of two, so the index decode must cover a partly used range, and the last entry is loaded and used directly. Address and limit widths stay at 32 and 20 with a 12-bit granularity shift. These widths put the 2^32 end-of-access overflow and the {limit, FFFh} expansion in reach, alongside the real-mode carry into bit 20.

// File: rtl/seg_agu_pkg.sv
package seg_agu_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_EXEC  = 2'd2
   } acc_kind_e;

   typedef enum logic [1:0] {
      FLT_NONE  = 2'd0,
      FLT_LIMIT = 2'd1,
      FLT_RIGHT = 2'd2,
      FLT_ABSNT = 2'd3
   } flt_code_e;

endpackage

// File: rtl/seg_agu_cache.sv
module seg_agu_cache #(
   parameter int SEG_CNT = 4,
   parameter int ADDR_W  = 32,
   parameter int LIM_W   = 20,
   localparam int IDX_W  = (SEG_CNT > 1) ? $clog2(SEG_CNT) : 1,
   localparam int ENT_W  = 16 + ADDR_W + LIM_W + 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [ENT_W-1:0]  wr_ent,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [ENT_W-1:0]  rd_ent
);

   logic [ENT_W-1:0] ent_q [SEG_CNT];

   // Entry layout: {selector, base, limit, gran, present, code, rw}.
   // Bit 2 is the present flag, so an entry that is still at reset is absent.
   localparam int PRES_BIT = 2;

   for (genvar g = 0; g < SEG_CNT; g++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ent_q[g] <= '0;
         else if (wr_en && wr_ent[PRES_BIT] && (wr_idx == IDX_W'(g)))
            ent_q[g] <= wr_ent;
      end

      a_r5_keep_entry: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && !wr_ent[PRES_BIT]) |=> $stable(ent_q[g]));
   end

   always_comb begin
      rd_ent = '0;
      for (int i = 0; i < SEG_CNT; i++)
         if (rd_idx == IDX_W'(i)) rd_ent = ent_q[i];
   end

endmodule

// File: rtl/seg_agu_check.sv
module seg_agu_check
   import seg_agu_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LIM_W      = 20,
   parameter int GRAN_SHIFT = 12
) (
   input  logic              pe,
   input  logic [ADDR_W-1:0] offset,
   input  logic [1:0]        kind,
   input  logic [1:0]        size,
   input  logic [LIM_W-1:0]  limit,
   input  logic              gran,
   input  logic              present,
   input  logic              code,
   input  logic              rw,
   output flt_code_e         fault
);

   localparam int CW = ADDR_W + 1;

   logic [CW-1:0] last_byte;
   logic [CW-1:0] eff_limit;
   logic          rights_bad;
   logic          limit_bad;

   assign last_byte = {1'b0, offset} + CW'(size);
   assign eff_limit = gran ? CW'({limit, {GRAN_SHIFT{1'b1}}}) : CW'(limit);
   assign limit_bad = last_byte > eff_limit;

   always_comb begin
      unique case (kind)
         ACC_WRITE: rights_bad = code || !rw;
         ACC_EXEC:  rights_bad = !code;
         ACC_READ:  rights_bad = code && !rw;
         default:   rights_bad = 1'b1;
      endcase
   end

   always_comb begin
      if (!pe)              fault = FLT_NONE;
      else if (!present)    fault = FLT_ABSNT;
      else if (rights_bad)  fault = FLT_RIGHT;
      else if (limit_bad)   fault = FLT_LIMIT;
      else                  fault = FLT_NONE;
   end

endmodule

// File: rtl/seg_agu_form.sv
module seg_agu_form #(
   parameter int ADDR_W = 32
) (
   input  logic              pe,
   input  logic              a20_mask_n,
   input  logic [15:0]       seg_val,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] offset,
   output logic [ADDR_W-1:0] lin
);

   logic [20:0]       real_sum;
   logic [ADDR_W-1:0] raw;

   assign real_sum = {1'b0, seg_val, 4'h0} + {5'h0, offset[15:0]};
   assign raw      = pe ? (base + offset) : ADDR_W'(real_sum);

   always_comb begin
      lin     = raw;
      lin[20] = raw[20] & a20_mask_n;
   end

endmodule

// File: rtl/seg_agu.sv
module seg_agu
   import seg_agu_pkg::*;
#(
   parameter int SEG_CNT    = 4,
   parameter int ADDR_W     = 32,
   parameter int LIM_W      = 20,
   parameter int GRAN_SHIFT = 12,
   localparam int IDX_W     = (SEG_CNT > 1) ? $clog2(SEG_CNT) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_pe,
   input  logic              a20_mask_n,
   input  logic              ld_valid,
   input  logic [IDX_W-1:0]  ld_seg_idx,
   input  logic [15:0]       ld_selector,
   input  logic [ADDR_W-1:0] ld_base,
   input  logic [LIM_W-1:0]  ld_limit,
   input  logic              ld_gran,
   input  logic              ld_present,
   input  logic              ld_code,
   input  logic              ld_rw,
   input  logic              req_valid,
   input  logic [IDX_W-1:0]  req_seg_idx,
   input  logic [15:0]       req_seg_val,
   input  logic [ADDR_W-1:0] req_offset,
   input  logic [1:0]        req_kind,
   input  logic [1:0]        req_size,
   output logic              ld_fault,
   output logic              rsp_valid,
   output logic [ADDR_W-1:0] rsp_addr,
   output logic [1:0]        rsp_fault,
   output logic              rsp_ti,
   output logic [1:0]        rsp_rpl,
   output logic [12:0]       rsp_index
);

   localparam int ENT_W = 16 + ADDR_W + LIM_W + 4;

   if (SEG_CNT < 1)                   begin : g_bad_cnt  $error("SEG_CNT must be at least 1"); end
   if (ADDR_W < 21)                   begin : g_bad_addr $error("ADDR_W must cover bit 20"); end
   if (LIM_W + GRAN_SHIFT > ADDR_W)   begin : g_bad_lim  $error("scaled limit wider than address"); end

   logic [ENT_W-1:0]  ent;
   logic [15:0]       e_sel;
   logic [ADDR_W-1:0] e_base;
   logic [LIM_W-1:0]  e_lim;
   logic              e_gran, e_pres, e_code, e_rw;
   logic [ADDR_W-1:0] lin;
   flt_code_e         flt;

   seg_agu_cache #(.SEG_CNT(SEG_CNT), .ADDR_W(ADDR_W), .LIM_W(LIM_W)) u_cache (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (ld_valid),
      .wr_idx (ld_seg_idx),
      .wr_ent ({ld_selector, ld_base, ld_limit, ld_gran, ld_present, ld_code, ld_rw}),
      .rd_idx (req_seg_idx),
      .rd_ent (ent)
   );

   assign {e_sel, e_base, e_lim, e_gran, e_pres, e_code, e_rw} = ent;

   seg_agu_check #(.ADDR_W(ADDR_W), .LIM_W(LIM_W), .GRAN_SHIFT(GRAN_SHIFT)) u_check (
      .pe      (ctl_pe),
      .offset  (req_offset),
      .kind    (req_kind),
      .size    (req_size),
      .limit   (e_lim),
      .gran    (e_gran),
      .present (e_pres),
      .code    (e_code),
      .rw      (e_rw),
      .fault   (flt)
   );

   seg_agu_form #(.ADDR_W(ADDR_W)) u_form (
      .pe         (ctl_pe),
      .a20_mask_n (a20_mask_n),
      .seg_val    (req_seg_val),
      .base       (e_base),
      .offset     (req_offset),
      .lin        (lin)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ld_fault  <= 1'b0;
         rsp_valid <= 1'b0;
         rsp_addr  <= '0;
         rsp_fault <= '0;
         rsp_ti    <= 1'b0;
         rsp_rpl   <= '0;
         rsp_index <= '0;
      end else begin
         ld_fault  <= ld_valid && !ld_present;
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_fault <= flt;
            rsp_addr  <= (flt == FLT_NONE) ? lin : '0;
            rsp_ti    <= ctl_pe & e_sel[2];
            rsp_rpl   <= ctl_pe ? e_sel[1:0] : 2'b00;
            rsp_index <= ctl_pe ? e_sel[15:3] : 13'h0;
         end
      end
   end

   a_r3_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   a_r2_bit20_low: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !a20_mask_n) |=> !rsp_addr[20]);
   a_r1_real_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !ctl_pe) |=> (rsp_fault == 2'd0));
   a_r10_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_fault != 2'd0) |-> (rsp_addr == '0));

endmodule

// File: tb/sim_seg_agu.sv
module sim_seg_agu;

   localparam int SEG_CNT = 6;
   localparam int IDX_W   = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_pe = 1'b0, a20_mask_n = 1'b1;
   logic        ld_valid = 1'b0;
   logic [IDX_W-1:0] ld_seg_idx = '0;
   logic [15:0] ld_selector = '0;
   logic [31:0] ld_base = '0;
   logic [19:0] ld_limit = '0;
   logic        ld_gran = 1'b0, ld_present = 1'b0, ld_code = 1'b0, ld_rw = 1'b0;
   logic        req_valid = 1'b0;
   logic [IDX_W-1:0] req_seg_idx = '0;
   logic [15:0] req_seg_val = '0;
   logic [31:0] req_offset = '0;
   logic [1:0]  req_kind = '0, req_size = '0;
   logic        ld_fault, rsp_valid, rsp_ti;
   logic [31:0] rsp_addr;
   logic [1:0]  rsp_fault, rsp_rpl;
   logic [12:0] rsp_index;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   seg_agu #(.SEG_CNT(SEG_CNT)) u0 (.*);

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic load(int idx, logic [15:0] sel, logic [31:0] base, logic [19:0] lim,
                       logic g, logic p, logic c, logic rw);
      @(negedge clk);
      ld_valid = 1'b1; ld_seg_idx = IDX_W'(idx); ld_selector = sel; ld_base = base;
      ld_limit = lim; ld_gran = g; ld_present = p; ld_code = c; ld_rw = rw;
      @(negedge clk);
      ld_valid = 1'b0;
   endtask

   task automatic xlate(int idx, logic [15:0] sv, logic [31:0] off, logic [1:0] kind,
                        logic [1:0] size);
      @(negedge clk);
      req_valid = 1'b1; req_seg_idx = IDX_W'(idx); req_seg_val = sv;
      req_offset = off; req_kind = kind; req_size = size;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic t_reset;
      chk("R3 reset rsp_valid", 32'(rsp_valid), 0);
      chk("R10 reset addr", rsp_addr, 0);
      chk("R5 reset ld_fault", 32'(ld_fault), 0);
   endtask

   task automatic t_real;
      ctl_pe = 1'b0;
      xlate(0, 16'h1234, 32'hABCD_5678, 2'd1, 2'd3);
      chk("R1 real addr", rsp_addr, 32'h0001_79B8);
      chk("R1 real no fault", 32'(rsp_fault), 0);
      chk("R3 rsp_valid", 32'(rsp_valid), 1);
      chk("R4 real ti/rpl zero", {29'h0, rsp_ti, rsp_rpl}, 0);
      xlate(0, 16'hFFFF, 32'h0000_FFFF, 2'd0, 2'd0);
      chk("R2 carry past 1MB", rsp_addr, 32'h0010_FFEF);
      a20_mask_n = 1'b0;
      xlate(0, 16'hFFFF, 32'h0000_FFFF, 2'd0, 2'd0);
      chk("R2 bit20 masked", rsp_addr, 32'h0000_FFEF);
      a20_mask_n = 1'b1;
      @(negedge clk);
      chk("R3 idle no rsp", 32'(rsp_valid), 0);
   endtask

   task automatic t_absent;
      ctl_pe = 1'b1;
      xlate(0, 16'h0, 32'h10, 2'd0, 2'd0);
      chk("R9 never loaded", 32'(rsp_fault), 3);
      chk("R10 addr zero", rsp_addr, 0);
   endtask

   task automatic t_byte_limit;
      ctl_pe = 1'b1;
      load(2, 16'h001F, 32'h0010_0000, 20'h00FFF, 1'b0, 1'b1, 1'b0, 1'b1);
      chk("R5 present load ok", 32'(ld_fault), 0);
      xlate(2, 16'h0, 32'h0000_0FFC, 2'd1, 2'd3);
      chk("R6 last byte at limit", 32'(rsp_fault), 0);
      chk("R4 base+offset", rsp_addr, 32'h0010_0FFC);
      chk("R4 ti", 32'(rsp_ti), 1);
      chk("R4 rpl", 32'(rsp_rpl), 3);
      chk("R4 index", 32'(rsp_index), 3);
      xlate(2, 16'h0, 32'h0000_0FFD, 2'd1, 2'd3);
      chk("R6 one past limit", 32'(rsp_fault), 1);
      chk("R10 addr zero", rsp_addr, 0);
      a20_mask_n = 1'b0;
      xlate(2, 16'h0, 32'h0000_0010, 2'd0, 2'd0);
      chk("R2 mask protected", rsp_addr, 32'h0000_0010);
      a20_mask_n = 1'b1;
   endtask

   task automatic t_refused;
      ctl_pe = 1'b1;
      load(2, 16'hFFF8, 32'h7777_0000, 20'hFFFFF, 1'b1, 1'b0, 1'b1, 1'b0);
      chk("R5 refused flag", 32'(ld_fault), 1);
      xlate(2, 16'h0, 32'h0000_0010, 2'd1, 2'd0);
      chk("R5 old entry kept", rsp_addr, 32'h0010_0010);
      chk("R5 old selector kept", 32'(rsp_index), 3);
   endtask

   task automatic t_code_gran;
      ctl_pe = 1'b1;
      load(5, 16'h0008, 32'h4000_0000, 20'h00001, 1'b1, 1'b1, 1'b1, 1'b1);
      xlate(5, 16'h0, 32'h0000_1FFF, 2'd2, 2'd0);
      chk("R7 exec at scaled limit", rsp_addr, 32'h4000_1FFF);
      xlate(5, 16'h0, 32'h0000_1FFE, 2'd0, 2'd1);
      chk("R8 read readable code", 32'(rsp_fault), 0);
      xlate(5, 16'h0, 32'h0000_2000, 2'd2, 2'd0);
      chk("R7 past scaled limit", 32'(rsp_fault), 1);
      xlate(5, 16'h0, 32'h0, 2'd1, 2'd0);
      chk("R8 write to code", 32'(rsp_fault), 2);
      xlate(5, 16'h0, 32'h0000_2000, 2'd1, 2'd0);
      chk("R8 rights before limit", 32'(rsp_fault), 2);
      load(4, 16'h0010, 32'h0, 20'hFFFFF, 1'b0, 1'b1, 1'b1, 1'b0);
      xlate(4, 16'h0, 32'h0, 2'd0, 2'd0);
      chk("R8 read unreadable code", 32'(rsp_fault), 2);
   endtask

   task automatic t_readonly;
      ctl_pe = 1'b1;
      load(1, 16'h0018, 32'hFFFF_F000, 20'hFFFFF, 1'b1, 1'b1, 1'b0, 1'b0);
      xlate(1, 16'h0, 32'h0000_2000, 2'd0, 2'd0);
      chk("R4 base wrap", rsp_addr, 32'h0000_1000);
      xlate(1, 16'h0, 32'h0000_2000, 2'd1, 2'd0);
      chk("R8 write read-only", 32'(rsp_fault), 2);
      xlate(1, 16'h0, 32'h0000_2000, 2'd2, 2'd0);
      chk("R8 exec from data", 32'(rsp_fault), 2);
      xlate(1, 16'h0, 32'hFFFF_FFFF, 2'd0, 2'd1);
      chk("R7 end past 4G", 32'(rsp_fault), 1);
      xlate(1, 16'h0, 32'hFFFF_FFFF, 2'd0, 2'd0);
      chk("R7 last byte of 4G", 32'(rsp_fault), 0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_real();
      t_absent();
      t_byte_limit();
      t_refused();
      t_code_gran();
      t_readonly();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule